// File: doc/BRIEF.md
# 8-bit ALU with flags

This block is the combinational arithmetic and logic unit of a small 8-bit microcontroller datapath. It takes two operands, the current carry and auxiliary-carry flags and a 5-bit operation code. From these it produces an 8-bit result, new values for the carry (C), auxiliary carry (AC), zero (Z) and overflow (OV) flags, one write enable per flag, and a skip decision used by conditional-skip instructions.

The surrounding core owns the status storage. It writes each flag only when that flag's enable is high, so operations that must leave a flag alone simply hold its enable low. Subtraction follows the "carry means no borrow" convention. Decimal adjust uses the incoming AC and C flags to correct a packed-BCD sum.

Top module: `alu8_core`

## Requirements
- R1: ADD (code 0) gives a+b and ADC (code 1) gives a+b+c_in, each modulo 256. C is the carry out of bit 7, and all four flag enables are high for both.
- R2: SUB (code 2) computes a+~b+1 and SBC (code 3) computes a+~b+c_in. C is 1 when no borrow occurs, and all four flag enables are high for both.
- R3: For codes 0 to 3, AC is the carry out of bit 3 of that same addition. For subtraction this means AC is 1 when no borrow passes into the low nibble.
- R4: For codes 0 to 3, OV is 1 exactly when the carry into bit 7 differs from the carry out of bit 7.
- R5: Whenever z_we is high, z_out is 1 if and only if res_out is 0x00.
- R6: AND (5), OR (6), XOR (7) and CPL (8, which gives ~a and ignores b) raise only z_we.
- R7: RL (9) and RR (10) rotate a circularly and raise no flag enable. RLC (11) and RRC (12) rotate through the carry: c_in fills the vacated bit, and the bit shifted out becomes C. Only c_we is raised for them.
- R8: INC (13) gives a+1 and DEC (14) gives a-1, each modulo 256, and only z_we is raised.
- R9: DAA (4) works in two steps, and only c_we is raised. First it adds 0x06 if a[3:0]>9 or ac_in is 1, giving a 9-bit sum t. It then adds 0x60 if t[7:4]>9, c_in is 1 or t[8] is 1. C is 1 exactly when this second correction is applied.
- R10: SZ (15) skips when a is 0x00 and SNZ (16) skips when a is nonzero; both return a. ISZ (17) returns a+1 and DSZ (18) returns a-1, and both skip when that updated value is 0x00. None of the four raises a flag enable.
- R11: Codes 19 to 31 return a, raise no flag enable and never skip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 8 | First operand (accumulator side) |
| b_in | input | 8 | Second operand |
| c_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary carry flag |
| op_sel | input | 5 | Operation code |
| res_out | output | 8 | Operation result |
| c_out | output | 1 | New carry value |
| ac_out | output | 1 | New auxiliary carry value |
| z_out | output | 1 | New zero value |
| ov_out | output | 1 | New overflow value |
| c_we | output | 1 | Carry write enable |
| ac_we | output | 1 | Auxiliary carry write enable |
| z_we | output | 1 | Zero write enable |
| ov_we | output | 1 | Overflow write enable |
| skip_out | output | 1 | Skip the next instruction |

## Verification
The operands 0x7F, 0x80, 0xFF and 0x00 are used because each one moves a single carry boundary. Together they separate carry out of bit 7 from carry into bit 7, which is what isolates overflow, and carry out of bit 3, which isolates the AC flag. Subtract-with-borrow runs with c_in both set and clear on equal operands, so a zero result with no borrow can be told apart from 0xFF with a borrow. The DAA cases cover a low-nibble fix only, a double fix that wraps, a fix forced by the incoming flags, and no fix at all. A long random run over every code, including unused ones, is compared against an integer model of the requirements.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int OPW = 5;

    localparam logic [OPW-1:0] OP_ADD = 5'd0;
    localparam logic [OPW-1:0] OP_ADC = 5'd1;
    localparam logic [OPW-1:0] OP_SUB = 5'd2;
    localparam logic [OPW-1:0] OP_SBC = 5'd3;
    localparam logic [OPW-1:0] OP_DAA = 5'd4;
    localparam logic [OPW-1:0] OP_AND = 5'd5;
    localparam logic [OPW-1:0] OP_OR  = 5'd6;
    localparam logic [OPW-1:0] OP_XOR = 5'd7;
    localparam logic [OPW-1:0] OP_CPL = 5'd8;
    localparam logic [OPW-1:0] OP_RL  = 5'd9;
    localparam logic [OPW-1:0] OP_RR  = 5'd10;
    localparam logic [OPW-1:0] OP_RLC = 5'd11;
    localparam logic [OPW-1:0] OP_RRC = 5'd12;
    localparam logic [OPW-1:0] OP_INC = 5'd13;
    localparam logic [OPW-1:0] OP_DEC = 5'd14;
    localparam logic [OPW-1:0] OP_SZ  = 5'd15;
    localparam logic [OPW-1:0] OP_SNZ = 5'd16;
    localparam logic [OPW-1:0] OP_ISZ = 5'd17;
    localparam logic [OPW-1:0] OP_DSZ = 5'd18;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          c;
        logic          ac;
        logic          z;
        logic          ov;
        logic          c_we;
        logic          ac_we;
        logic          z_we;
        logic          ov_we;
        logic          skip;
    } alu_out_t;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
(
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  logic           cin,
    input  logic           acin,
    output logic [DW-1:0]  res,
    output logic           c,
    output logic           ac,
    output logic           ov,
    output logic           z
);
    localparam int MW = DW - 1 - NW;
    localparam logic [DW:0]   LO_ADJ = (DW+1)'(6);
    localparam logic [DW-1:0] HI_ADJ = DW'(8'h60);

    logic [DW-1:0] bx;
    logic          ci;
    logic [NW:0]   lo_s;
    logic [MW:0]   mid_s;
    logic [1:0]    top_s;
    logic [DW-1:0] sum;
    logic          lo_fix, hi_fix;
    logic [DW:0]   t_d;
    logic [DW-1:0] daa_d;

    always_comb begin
        bx = '0;
        ci = 1'b0;
        case (op)
            OP_ADD:         begin bx = b;           ci = 1'b0; end
            OP_ADC:         begin bx = b;           ci = cin;  end
            OP_SUB:         begin bx = ~b;          ci = 1'b1; end
            OP_SBC:         begin bx = ~b;          ci = cin;  end
            OP_INC, OP_ISZ: begin bx = DW'(1);      ci = 1'b0; end
            OP_DEC, OP_DSZ: begin bx = '1;          ci = 1'b0; end
            default:        begin bx = '0;          ci = 1'b0; end
        endcase
    end

    assign lo_s  = {1'b0, a[NW-1:0]} + {1'b0, bx[NW-1:0]} + {{NW{1'b0}}, ci};
    assign mid_s = {1'b0, a[DW-2:NW]} + {1'b0, bx[DW-2:NW]} + {{MW{1'b0}}, lo_s[NW]};
    assign top_s = {1'b0, a[DW-1]} + {1'b0, bx[DW-1]} + {1'b0, mid_s[MW]};
    assign sum   = {top_s[0], mid_s[MW-1:0], lo_s[NW-1:0]};

    always_comb begin
        lo_fix = (a[NW-1:0] > NW'(9)) || acin;
        t_d    = {1'b0, a} + (lo_fix ? LO_ADJ : '0);
        hi_fix = (t_d[DW-1:NW] > NW'(9)) || cin || t_d[DW];
        daa_d  = t_d[DW-1:0] + (hi_fix ? HI_ADJ : '0);
    end

    always_comb begin
        if (op == OP_DAA) begin
            res = daa_d;
            c   = hi_fix;
        end else begin
            res = sum;
            c   = top_s[1];
        end
        ac = lo_s[NW];
        ov = mid_s[MW] ^ top_s[1];
        z  = (res != '0) ? 1'b0 : 1'b1;
    end
endmodule

// File: rtl/alu8_shlog.sv
module alu8_shlog
    import alu8_pkg::*;
(
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  logic           cin,
    output logic [DW-1:0]  res,
    output logic           c
);
    always_comb begin
        res = a;
        c   = cin;
        case (op)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_CPL: res = ~a;
            OP_RL:  res = {a[DW-2:0], a[DW-1]};
            OP_RR:  res = {a[0], a[DW-1:1]};
            OP_RLC: begin res = {a[DW-2:0], cin}; c = a[DW-1]; end
            OP_RRC: begin res = {cin, a[DW-1:1]}; c = a[0];    end
            default: begin res = a; c = cin; end
        endcase
    end
endmodule

// File: rtl/alu8_skip.sv
module alu8_skip
    import alu8_pkg::*;
(
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  upd,
    output logic           skip
);
    always_comb begin
        case (op)
            OP_SZ:          skip = (a == '0);
            OP_SNZ:         skip = (a != '0);
            OP_ISZ, OP_DSZ: skip = (upd == '0);
            default:        skip = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [7:0] a_in,
    input  logic [7:0] b_in,
    input  logic       c_in,
    input  logic       ac_in,
    input  logic [4:0] op_sel,
    output logic [7:0] res_out,
    output logic       c_out,
    output logic       ac_out,
    output logic       z_out,
    output logic       ov_out,
    output logic       c_we,
    output logic       ac_we,
    output logic       z_we,
    output logic       ov_we,
    output logic       skip_out
);
    logic [DW-1:0] ar_res, sl_res;
    logic          ar_c, ar_ac, ar_ov, ar_z, sl_c, sk;
    alu_out_t      nxt_d;

    alu8_arith u_arith (
        .op(op_sel), .a(a_in), .b(b_in), .cin(c_in), .acin(ac_in),
        .res(ar_res), .c(ar_c), .ac(ar_ac), .ov(ar_ov), .z(ar_z)
    );

    alu8_shlog u_shlog (
        .op(op_sel), .a(a_in), .b(b_in), .cin(c_in),
        .res(sl_res), .c(sl_c)
    );

    alu8_skip u_skip (
        .op(op_sel), .a(a_in), .upd(ar_res), .skip(sk)
    );

    always_comb begin
        nxt_d       = '0;
        nxt_d.res   = a_in;
        nxt_d.c     = c_in;
        nxt_d.ac    = ac_in;
        nxt_d.ov    = 1'b0;
        nxt_d.skip  = sk;
        case (op_sel)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                nxt_d.res   = ar_res;
                nxt_d.c     = ar_c;
                nxt_d.ac    = ar_ac;
                nxt_d.ov    = ar_ov;
                nxt_d.c_we  = 1'b1;
                nxt_d.ac_we = 1'b1;
                nxt_d.z_we  = 1'b1;
                nxt_d.ov_we = 1'b1;
            end
            OP_DAA: begin
                nxt_d.res  = ar_res;
                nxt_d.c    = ar_c;
                nxt_d.c_we = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR, OP_CPL: begin
                nxt_d.res  = sl_res;
                nxt_d.z_we = 1'b1;
            end
            OP_RL, OP_RR: nxt_d.res = sl_res;
            OP_RLC, OP_RRC: begin
                nxt_d.res  = sl_res;
                nxt_d.c    = sl_c;
                nxt_d.c_we = 1'b1;
            end
            OP_INC, OP_DEC: begin
                nxt_d.res  = ar_res;
                nxt_d.z_we = 1'b1;
            end
            OP_ISZ, OP_DSZ: nxt_d.res = ar_res;
            default: nxt_d.res = a_in;
        endcase
        nxt_d.z = ~|nxt_d.res;
    end

    assign res_out  = nxt_d.res;
    assign c_out    = nxt_d.c;
    assign ac_out   = nxt_d.ac;
    assign z_out    = nxt_d.z;
    assign ov_out   = nxt_d.ov;
    assign c_we     = nxt_d.c_we;
    assign ac_we    = nxt_d.ac_we;
    assign z_we     = nxt_d.z_we;
    assign ov_we    = nxt_d.ov_we;
    assign skip_out = nxt_d.skip;

    always_comb begin
        if (op_sel == OP_ADD) begin
            AST_ADD_SUM: assert ({c_out, res_out} == ({1'b0, a_in} + {1'b0, b_in})) else $error("add sum"); // R1
            AST_ADD_OVF: assert (ov_out == ((a_in[DW-1] == b_in[DW-1]) && (res_out[DW-1] != a_in[DW-1]))) else $error("add ovf"); // R4
        end
        if (op_sel == OP_SUB) begin
            AST_SUB_NOBORROW: assert (c_out == (a_in >= b_in)) else $error("sub carry"); // R2
        end
        if (z_we && (op_sel == OP_INC || op_sel == OP_DEC || op_sel <= OP_SBC)) begin
            AST_ZERO_AGREE: assert (z_out == ar_z) else $error("zero flag"); // R5
        end
        if (skip_out && (op_sel == OP_ISZ || op_sel == OP_DSZ)) begin
            AST_SKIP_ON_ZERO: assert (res_out == '0) else $error("skip result"); // R10
        end
        if (op_sel > OP_DSZ) begin
            AST_UNUSED_QUIET: assert (!skip_out && !c_we && !ac_we && !z_we && !ov_we && res_out == a_in) else $error("unused code"); // R11
        end
    end
endmodule

// File: tb/alu8_core_test.sv
module alu8_core_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;
    logic rst;

    logic [7:0] a_in, b_in, res_out;
    logic       c_in, ac_in, c_out, ac_out, z_out, ov_out;
    logic       c_we, ac_we, z_we, ov_we, skip_out;
    logic [4:0] op_sel;

    int total = 0;
    int bad   = 0;

    alu8_core uut (
        .a_in(a_in), .b_in(b_in), .c_in(c_in), .ac_in(ac_in), .op_sel(op_sel),
        .res_out(res_out), .c_out(c_out), .ac_out(ac_out), .z_out(z_out), .ov_out(ov_out),
        .c_we(c_we), .ac_we(ac_we), .z_we(z_we), .ov_we(ov_we), .skip_out(skip_out)
    );

    // fl and we order: {C, AC, Z, OV}
    typedef struct packed {
        logic [4:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic       c;
        logic       ac;
        logic [7:0] res;
        logic [3:0] fl;
        logic [3:0] we;
        logic       skip;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{5'd0,  8'h7F, 8'h01, 1'b0, 1'b0, 8'h80, 4'b0101, 4'b1111, 1'b0}, // R1 R4
        '{5'd0,  8'hFF, 8'h01, 1'b0, 1'b0, 8'h00, 4'b1110, 4'b1111, 1'b0}, // R1 R3 R5
        '{5'd1,  8'h80, 8'h80, 1'b1, 1'b0, 8'h01, 4'b1001, 4'b1111, 1'b0}, // R1 R4
        '{5'd2,  8'h00, 8'h01, 1'b0, 1'b0, 8'hFF, 4'b0000, 4'b1111, 1'b0}, // R2
        '{5'd2,  8'h80, 8'h01, 1'b0, 1'b0, 8'h7F, 4'b1001, 4'b1111, 1'b0}, // R2 R4
        '{5'd3,  8'h05, 8'h05, 1'b0, 1'b0, 8'hFF, 4'b0000, 4'b1111, 1'b0}, // R2 R3
        '{5'd3,  8'h05, 8'h05, 1'b1, 1'b0, 8'h00, 4'b1110, 4'b1111, 1'b0}, // R2 R3
        '{5'd5,  8'hF0, 8'h3C, 1'b1, 1'b1, 8'h30, 4'b0000, 4'b0010, 1'b0}, // R6
        '{5'd6,  8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 4'b0010, 4'b0010, 1'b0}, // R6
        '{5'd7,  8'h5A, 8'h5A, 1'b0, 1'b0, 8'h00, 4'b0010, 4'b0010, 1'b0}, // R6
        '{5'd8,  8'hFF, 8'h12, 1'b0, 1'b0, 8'h00, 4'b0010, 4'b0010, 1'b0}, // R6
        '{5'd9,  8'h81, 8'h00, 1'b0, 1'b0, 8'h03, 4'b0000, 4'b0000, 1'b0}, // R7
        '{5'd10, 8'h01, 8'h00, 1'b0, 1'b0, 8'h80, 4'b0000, 4'b0000, 1'b0}, // R7
        '{5'd11, 8'h80, 8'h00, 1'b0, 1'b0, 8'h00, 4'b1000, 4'b1000, 1'b0}, // R7
        '{5'd12, 8'h01, 8'h00, 1'b1, 1'b0, 8'h80, 4'b1000, 4'b1000, 1'b0}, // R7
        '{5'd12, 8'h02, 8'h00, 1'b0, 1'b0, 8'h01, 4'b0000, 4'b1000, 1'b0}, // R7
        '{5'd13, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 4'b0010, 4'b0010, 1'b0}, // R8
        '{5'd14, 8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 4'b0000, 4'b0010, 1'b0}, // R8
        '{5'd4,  8'h0A, 8'h00, 1'b0, 1'b0, 8'h10, 4'b0000, 4'b1000, 1'b0}, // R9
        '{5'd4,  8'h9A, 8'h00, 1'b0, 1'b0, 8'h00, 4'b1000, 4'b1000, 1'b0}, // R9
        '{5'd4,  8'h00, 8'h00, 1'b1, 1'b1, 8'h66, 4'b1000, 4'b1000, 1'b0}, // R9
        '{5'd4,  8'h45, 8'h00, 1'b0, 1'b0, 8'h45, 4'b0000, 4'b1000, 1'b0}, // R9
        '{5'd15, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 4'b0000, 4'b0000, 1'b1}, // R10
        '{5'd16, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 4'b0000, 4'b0000, 1'b0}, // R10
        '{5'd16, 8'h07, 8'h00, 1'b0, 1'b0, 8'h07, 4'b0000, 4'b0000, 1'b1}, // R10
        '{5'd17, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 4'b0000, 4'b0000, 1'b1}, // R10
        '{5'd18, 8'h02, 8'h00, 1'b0, 1'b0, 8'h01, 4'b0000, 4'b0000, 1'b0}, // R10
        '{5'd25, 8'h3C, 8'hC3, 1'b1, 1'b1, 8'h3C, 4'b0000, 4'b0000, 1'b0}  // R11
    };

    function automatic string req_of(int op);
        case (op)
            0, 1:           return "R1/R3/R4/R5";
            2, 3:           return "R2/R3/R4/R5";
            4:              return "R9";
            5, 6, 7, 8:     return "R6/R5";
            9, 10, 11, 12:  return "R7";
            13, 14:         return "R8/R5";
            15, 16, 17, 18: return "R10";
            default:        return "R11";
        endcase
    endfunction

    function automatic vec_t model(int op, int a, int b, int c, int ac);
        vec_t e;
        int s, bb, k, t;
        logic hi;
        e = '0;
        e.op = 5'(op); e.a = 8'(a); e.b = 8'(b); e.c = 1'(c); e.ac = 1'(ac);
        e.res = 8'(a);
        case (op)
            0, 1, 2, 3: begin
                bb = (op >= 2) ? 255 - b : b;
                k  = (op == 0) ? 0 : (op == 2) ? 1 : c;
                s  = a + bb + k;
                e.res = 8'(s);
                e.fl  = {s > 255, ((a % 16) + (bb % 16) + k) > 15, (s % 256) == 0,
                         ((a ^ s) & (bb ^ s) & 128) != 0};
                e.we  = 4'b1111;
            end
            4: begin
                t = a;
                if ((a % 16) > 9 || ac != 0) t = t + 6;
                hi = (((t / 16) % 16) > 9) || (c != 0) || (t > 255);
                if (hi) t = t + 96;
                e.res = 8'(t);
                e.fl  = {hi, 3'b000};
                e.we  = 4'b1000;
            end
            5, 6, 7, 8: begin
                if (op == 5) e.res = 8'(a & b);
                if (op == 6) e.res = 8'(a | b);
                if (op == 7) e.res = 8'(a ^ b);
                if (op == 8) e.res = 8'(255 - a);
                e.fl = {2'b00, e.res == 0, 1'b0};
                e.we = 4'b0010;
            end
            9:  e.res = 8'((a * 2) + (a / 128));
            10: e.res = 8'((a / 2) + (a % 2) * 128);
            11: begin e.res = 8'(a * 2 + c); e.fl = {a >= 128, 3'b000}; e.we = 4'b1000; end
            12: begin e.res = 8'(a / 2 + c * 128); e.fl = {(a % 2) == 1, 3'b000}; e.we = 4'b1000; end
            13, 14: begin
                e.res = 8'((op == 13) ? a + 1 : a + 255);
                e.fl  = {2'b00, e.res == 0, 1'b0};
                e.we  = 4'b0010;
            end
            15: e.skip = (a == 0);
            16: e.skip = (a != 0);
            17, 18: begin
                e.res  = 8'((op == 17) ? a + 1 : a + 255);
                e.skip = (e.res == 0);
            end
            default: e.res = 8'(a);
        endcase
        return e;
    endfunction

    task automatic run_check(input vec_t v, input string tag);
        logic [3:0] got_fl, got_we;
        @(posedge clk);
        op_sel = v.op; a_in = v.a; b_in = v.b; c_in = v.c; ac_in = v.ac;
        @(negedge clk);
        got_fl = {c_out, ac_out, z_out, ov_out};
        got_we = {c_we, ac_we, z_we, ov_we};
        total++;
        if (res_out !== v.res || got_we !== v.we || skip_out !== v.skip ||
            ((got_fl ^ v.fl) & v.we) != 4'b0000) begin
            bad++;
            $display("FAIL %s op=%0d a=%h b=%h c=%b ac=%b: got res=%h fl=%b we=%b skip=%b, expected res=%h fl=%b we=%b skip=%b",
                     tag, v.op, v.a, v.b, v.c, v.ac, res_out, got_fl, got_we, skip_out,
                     v.res, v.fl, v.we, v.skip);
        end
    endtask

    function automatic int pick_operand();
        int sel;
        sel = $urandom_range(0, 7);
        case (sel)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'h7F;
            3: return 8'h80;
            default: return $urandom_range(0, 255);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, got timeout, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        op_sel = 5'd0; a_in = 8'h00; b_in = 8'h00; c_in = 1'b0; ac_in = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // quiescent inputs after reset: ADD of zeros gives zero with Z set (R5)
        run_check(model(0, 0, 0, 0, 0), "R5 reset-state");
        for (int i = 0; i < NV; i++) begin
            run_check(VECS[i], req_of(int'(VECS[i].op)));
        end
        // every code with the four boundary operand pairs, both carry states
        for (int op = 0; op < 32; op++) begin
            for (int j = 0; j < 4; j++) begin
                int av, bv;
                av = (j == 0) ? 8'h00 : (j == 1) ? 8'hFF : (j == 2) ? 8'h7F : 8'h80;
                bv = (j == 0) ? 8'hFF : (j == 1) ? 8'h01 : (j == 2) ? 8'h80 : 8'h80;
                run_check(model(op, av, bv, j % 2, j / 2), req_of(op));
            end
        end
        for (int n = 0; n < 3000; n++) begin
            int op, av, bv, cv, acv;
            op  = $urandom_range(0, 31);
            av  = pick_operand();
            bv  = pick_operand();
            cv  = $urandom_range(0, 1);
            acv = $urandom_range(0, 1);
            run_check(model(op, av, bv, cv, acv), req_of(op));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule